// File: doc/BRIEF.md
# Configurable Bit-Stream FIFO

This block queues individual bits instead of whole words. A writer supplies data words together with an input command. The command gives the number of bits to take from each word and the order in which they enter the queue: lowest bit first, or highest taken bit first. A reader supplies an output command with three parts: a count of head bits to throw away, a count of bits to gather into the next output word, and a flag that chooses sign extension or zero extension. The data path and the two command paths each have their own valid/ready handshake.

Both commands stay in force after they are accepted. The input command applies to every later data word, and the output command applies to every later output word, until a new command replaces it. This lets one command set up a repeating pattern. For example, take 37 bits per word, then discard 37 and keep 1, which picks out one bit in every 38. The queue holds up to 128 bits. Output words are 37 bits wide, and the first gathered bit lands in bit 0.

Top module: `bit_stream_fifo`

## Requirements
- R1: Out of reset the queue is empty and no command is held. din_ready_o and dout_valid_o are 0, and iop_ready_o and oop_ready_o are 1.
- R2: An accepted input command with take count t enqueues t bits from each later accepted data word. A t above DATA_W (37) is treated as DATA_W.
- R3: With iop_lsb_first_i=1, bits enter as data[0], data[1], ..., data[t-1]. With iop_lsb_first_i=0, they enter as data[t-1] down to data[0].
- R4: A data word is accepted only when the free space (DEPTH=128 minus the bits held) is at least t. Occupancy never exceeds DEPTH.
- R5: dout_valid_o is 1 only when an output command is held and at least drop+take bits are queued. On the output handshake, drop+take bits leave the queue in that cycle.
- R6: The drop count of head bits is discarded before any bits are gathered.
- R7: The first gathered bit appears at dout_data_o[0], the next at bit 1, and so on.
- R8: With oop_sext_i=1, every bit above the gathered ones equals the last gathered bit. With oop_sext_i=0, those bits are 0. A take of 0 gives an all-zero word.
- R9: An accepted output command is reused for every following output word until a new one is accepted. No output is offered before the first output command.
- R10: A command accepted in a cycle affects only data or output words from the next cycle on. A data word accepted in the same cycle uses the previous input command.
- R11: With an input take of 37 and an output drop of 37 and take of 1, each output word carries the single bit that follows 37 discarded bits.
- R12: While dout_valid_o=1 and dout_ready_i=0, and no output command is offered, dout_valid_o stays 1 and dout_data_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iop_valid_i | input | 1 | Input command valid |
| iop_ready_o | output | 1 | Input command ready |
| iop_take_i | input | CNT_W | Bits to take per data word |
| iop_lsb_first_i | input | 1 | 1: low bit first, 0: high taken bit first |
| oop_valid_i | input | 1 | Output command valid |
| oop_ready_o | output | 1 | Output command ready |
| oop_drop_i | input | DROP_W | Head bits to discard per output word |
| oop_take_i | input | CNT_W | Bits to gather per output word |
| oop_sext_i | input | 1 | 1: sign extend, 0: zero extend |
| din_valid_i | input | 1 | Data word valid |
| din_ready_o | output | 1 | Data word ready |
| din_data_i | input | DATA_W | Data word |
| dout_valid_o | output | 1 | Output word valid |
| dout_ready_i | input | 1 | Output word ready |
| dout_data_o | output | DATA_W | Output word |

## Verification
The hold property assumes the reader offers no new output command while a word is waiting. The output word is computed from the held command, so replacing that command while a word waits would legally change the word. The bench changes the output command only while dout_ready_i is low and only after it has finished checking the current word. It also sizes every burst of writes so it fits in the free space before any read begins. The pop-count property covers only cycles with no push, so the bench keeps reads and writes in separate cycles.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  typedef enum logic {
    ORD_HIGH_FIRST = 1'b0,
    ORD_LOW_FIRST  = 1'b1
  } bit_order_e;

  localparam int unsigned DEF_DATA_W = 37;
  localparam int unsigned DEF_DEPTH  = 128;
endpackage

// File: rtl/bsf_op_hold.sv
module bsf_op_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] op_i,
  output logic [W-1:0] op_o,
  output logic         loaded_o
);
  logic [W-1:0] op_q;
  logic         loaded_q;

  assign ready_o  = 1'b1;
  assign op_o     = op_q;
  assign loaded_o = loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      loaded_q <= 1'b0;
    end else if (valid_i) begin
      op_q     <= op_i;
      loaded_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bsf_pack.sv
module bsf_pack
  import bsf_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  take_i,
  input  bit_order_e        order_i,
  output logic [DATA_W-1:0] lanes_o
);
  logic [DATA_W-1:0] rev;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev[i] = data_i[DATA_W-1-i];
  end

  // high-first: lane i = data[take-1-i]
  assign lanes_o = (order_i == ORD_LOW_FIRST) ? data_i
                 : (rev >> (CNT_W'(DATA_W) - take_i));
endmodule

// File: rtl/bsf_bit_store.sv
module bsf_bit_store
  import bsf_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1),
  parameter int unsigned DROP_W = CNT_W,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [CNT_W-1:0]  push_n_i,
  input  logic [DATA_W-1:0] lanes_i,
  input  logic              pop_i,
  input  logic [DROP_W-1:0] drop_i,
  input  logic [CNT_W-1:0]  take_i,
  output logic [DATA_W-1:0] win_o,
  output logic [OCC_W-1:0]  occ_o
);
  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [OCC_W-1:0] occ_q;
  logic [OCC_W-1:0] pop_amt, push_amt;

  assign pop_amt  = pop_i  ? (OCC_W'(drop_i) + OCC_W'(take_i)) : '0;
  assign push_amt = push_i ? OCC_W'(push_n_i) : '0;
  assign occ_o    = occ_q;

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      for (int i = 0; i < DATA_W; i++) begin
        if (i < int'(push_n_i)) mem_q[wr_ptr_q + PTR_W'(i)] <= lanes_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PTR_W'(push_n_i);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + PTR_W'(pop_amt);
      occ_q <= occ_q + push_amt - pop_amt;
    end
  end

  // window starts just past the dropped bits
  for (genvar j = 0; j < DATA_W; j++) begin : g_win
    assign win_o[j] = mem_q[rd_ptr_q + PTR_W'(drop_i) + PTR_W'(j)];
  end
endmodule

// File: rtl/bsf_extract.sv
module bsf_extract
  import bsf_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] win_i,
  input  logic [CNT_W-1:0]  take_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] data_o
);
  logic [CNT_W-1:0] last_idx;
  logic             fill;

  assign last_idx = take_i - CNT_W'(1);
  assign fill     = sext_i && (take_i != '0) && win_i[last_idx];

  for (genvar j = 0; j < DATA_W; j++) begin : g_ext
    assign data_o[j] = (CNT_W'(j) < take_i) ? win_i[j] : fill;
  end
endmodule

// File: rtl/bit_stream_fifo.sv
module bit_stream_fifo
  import bsf_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1),
  parameter int unsigned DROP_W = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iop_valid_i,
  output logic              iop_ready_o,
  input  logic [CNT_W-1:0]  iop_take_i,
  input  logic              iop_lsb_first_i,
  input  logic              oop_valid_i,
  output logic              oop_ready_o,
  input  logic [DROP_W-1:0] oop_drop_i,
  input  logic [CNT_W-1:0]  oop_take_i,
  input  logic              oop_sext_i,
  input  logic              din_valid_i,
  output logic              din_ready_o,
  input  logic [DATA_W-1:0] din_data_i,
  output logic              dout_valid_o,
  input  logic              dout_ready_i,
  output logic [DATA_W-1:0] dout_data_o
);
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam int unsigned IOP_W = CNT_W + 1;
  localparam int unsigned OOP_W = 1 + DROP_W + CNT_W;

  logic [CNT_W-1:0]  in_take_c, out_take_c;
  logic [IOP_W-1:0]  iop_q;
  logic [OOP_W-1:0]  oop_q;
  logic              iop_loaded, oop_loaded;
  logic [CNT_W-1:0]  in_take_q, out_take_q;
  logic [DROP_W-1:0] out_drop_q;
  logic              out_sext_q;
  bit_order_e        in_order_q;
  logic [DATA_W-1:0] lanes, win;
  logic [OCC_W-1:0]  occ, free_bits, need_bits;
  logic              push, pop;

  assign in_take_c  = (iop_take_i > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : iop_take_i;
  assign out_take_c = (oop_take_i > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : oop_take_i;

  bsf_op_hold #(.W(IOP_W)) i_iop_hold (
    .clk_i, .rst_ni,
    .valid_i (iop_valid_i),
    .ready_o (iop_ready_o),
    .op_i    ({iop_lsb_first_i, in_take_c}),
    .op_o    (iop_q),
    .loaded_o(iop_loaded)
  );

  bsf_op_hold #(.W(OOP_W)) i_oop_hold (
    .clk_i, .rst_ni,
    .valid_i (oop_valid_i),
    .ready_o (oop_ready_o),
    .op_i    ({oop_sext_i, oop_drop_i, out_take_c}),
    .op_o    (oop_q),
    .loaded_o(oop_loaded)
  );

  assign in_take_q  = iop_q[CNT_W-1:0];
  assign in_order_q = bit_order_e'(iop_q[CNT_W]);
  assign out_take_q = oop_q[CNT_W-1:0];
  assign out_drop_q = oop_q[CNT_W +: DROP_W];
  assign out_sext_q = oop_q[OOP_W-1];

  assign free_bits    = OCC_W'(DEPTH) - occ;
  assign need_bits    = OCC_W'(out_drop_q) + OCC_W'(out_take_q);
  assign din_ready_o  = iop_loaded && (free_bits >= OCC_W'(in_take_q));
  assign dout_valid_o = oop_loaded && (occ >= need_bits);
  assign push         = din_valid_i && din_ready_o;
  assign pop          = dout_valid_o && dout_ready_i;

  bsf_pack #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_pack (
    .data_i (din_data_i),
    .take_i (in_take_q),
    .order_i(in_order_q),
    .lanes_o(lanes)
  );

  bsf_bit_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .DROP_W(DROP_W)
  ) i_store (
    .clk_i, .rst_ni,
    .push_i  (push),
    .push_n_i(in_take_q),
    .lanes_i (lanes),
    .pop_i   (pop),
    .drop_i  (out_drop_q),
    .take_i  (out_take_q),
    .win_o   (win),
    .occ_o   (occ)
  );

  bsf_extract #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_extract (
    .win_i (win),
    .take_i(out_take_q),
    .sext_i(out_sext_q),
    .data_o(dout_data_o)
  );
endmodule

// File: rtl/bsf_checker.sv
module bsf_checker #(
  parameter int unsigned DATA_W = 37,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1),
  parameter int unsigned DROP_W = CNT_W,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              iop_valid_i,
  input logic              oop_valid_i,
  input logic              din_valid_i,
  input logic              din_ready_o,
  input logic              dout_valid_o,
  input logic              dout_ready_i,
  input logic [DATA_W-1:0] dout_data_o,
  input logic [OCC_W-1:0]  occ_i,
  input logic [CNT_W-1:0]  in_take_i,
  input logic [DROP_W-1:0] out_drop_i,
  input logic [CNT_W-1:0]  out_take_i,
  input logic              out_sext_i
);
  logic              seen_iop, seen_oop;
  logic [DATA_W-1:0] hi_mask;
  logic              last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_iop <= 1'b0;
      seen_oop <= 1'b0;
    end else begin
      if (iop_valid_i) seen_iop <= 1'b1;
      if (oop_valid_i) seen_oop <= 1'b1;
    end
  end

  always_comb begin
    hi_mask  = ~((DATA_W'(1) << out_take_i) - DATA_W'(1));
    last_bit = 1'b0;
    for (int j = 0; j < DATA_W; j++) begin
      if (int'(out_take_i) == j + 1) last_bit = dout_data_o[j];
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ_i) <= int'(DEPTH));

  assert_room_on_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_valid_i && din_ready_o |-> int'(DEPTH) - int'(occ_i) >= int'(in_take_i));

  assert_enough_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |-> int'(occ_i) >= int'(out_drop_i) + int'(out_take_i));

  assert_pop_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o && dout_ready_i && !(din_valid_i && din_ready_o) |=>
      int'(occ_i) == int'($past(occ_i)) - int'($past(out_drop_i)) - int'($past(out_take_i)));

  assert_extension_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o && out_take_i != '0 |->
      (dout_data_o & hi_mask) == ((out_sext_i && last_bit) ? hi_mask : '0));

  assert_take_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o && out_take_i == '0 |-> dout_data_o == '0);

  assert_no_out_before_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_oop |-> !dout_valid_o);

  assert_no_in_before_op_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_iop |-> !din_ready_o);

  assert_hold_while_stalled_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o && !dout_ready_i && !oop_valid_i |=> dout_valid_o && $stable(dout_data_o));
endmodule

bind bit_stream_fifo bsf_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .DROP_W(DROP_W)
) i_bsf_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iop_valid_i (iop_valid_i),
  .oop_valid_i (oop_valid_i),
  .din_valid_i (din_valid_i),
  .din_ready_o (din_ready_o),
  .dout_valid_o(dout_valid_o),
  .dout_ready_i(dout_ready_i),
  .dout_data_o (dout_data_o),
  .occ_i       (occ),
  .in_take_i   (in_take_q),
  .out_drop_i  (out_drop_q),
  .out_take_i  (out_take_q),
  .out_sext_i  (out_sext_q)
);

// File: tb/test_bit_stream_fifo.sv
`timescale 1ns/1ps
module test_bit_stream_fifo;
  localparam int DATA_W = 37;
  localparam int DEPTH  = 128;
  localparam int CNT_W  = 6;
  localparam int DROP_W = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              iop_valid_i = 1'b0, iop_ready_o;
  logic [CNT_W-1:0]  iop_take_i = '0;
  logic              iop_lsb_first_i = 1'b0;
  logic              oop_valid_i = 1'b0, oop_ready_o;
  logic [DROP_W-1:0] oop_drop_i = '0;
  logic [CNT_W-1:0]  oop_take_i = '0;
  logic              oop_sext_i = 1'b0;
  logic              din_valid_i = 1'b0, din_ready_o;
  logic [DATA_W-1:0] din_data_i = '0;
  logic              dout_valid_o, dout_ready_i = 1'b0;
  logic [DATA_W-1:0] dout_data_o;

  int checks = 0;
  int errors = 0;
  bit model_q[$];
  int cur_in_take = 0;
  bit cur_lsb = 0;
  int cur_drop = 0, cur_take = 0;
  bit cur_sext = 0;

  always #10 clk_i = ~clk_i;

  bit_stream_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .DROP_W(DROP_W)) i_bit_stream_fifo (
    .clk_i, .rst_ni,
    .iop_valid_i, .iop_ready_o, .iop_take_i, .iop_lsb_first_i,
    .oop_valid_i, .oop_ready_o, .oop_drop_i, .oop_take_i, .oop_sext_i,
    .din_valid_i, .din_ready_o, .din_data_i,
    .dout_valid_o, .dout_ready_i, .dout_data_o
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_iop(int take, bit lsb);
    @(negedge clk_i);
    iop_valid_i = 1'b1; iop_take_i = CNT_W'(take); iop_lsb_first_i = lsb;
    @(negedge clk_i);
    iop_valid_i = 1'b0;
    cur_in_take = (take > DATA_W) ? DATA_W : take;
    cur_lsb = lsb;
  endtask

  task automatic set_oop(int drop, int take, bit sext);
    @(negedge clk_i);
    oop_valid_i = 1'b1; oop_drop_i = DROP_W'(drop); oop_take_i = CNT_W'(take); oop_sext_i = sext;
    @(negedge clk_i);
    oop_valid_i = 1'b0;
    cur_drop = drop; cur_take = (take > DATA_W) ? DATA_W : take; cur_sext = sext;
  endtask

  function automatic void model_push(logic [DATA_W-1:0] d, int t, bit lsb);
    for (int i = 0; i < t; i++) model_q.push_back(lsb ? d[i] : d[t-1-i]);
  endfunction

  task automatic send_word(logic [DATA_W-1:0] d);
    @(negedge clk_i);
    din_valid_i = 1'b1; din_data_i = d;
    #1;
    while (!din_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    din_valid_i = 1'b0;
    model_push(d, cur_in_take, cur_lsb);
  endtask

  task automatic recv_word(string req, output logic [DATA_W-1:0] got);
    logic [DATA_W-1:0] exp;
    @(negedge clk_i);
    dout_ready_i = 1'b1;
    #1;
    while (!dout_valid_o) begin @(negedge clk_i); #1; end
    exp = '0;
    for (int j = 0; j < cur_drop; j++) void'(model_q.pop_front());
    for (int j = 0; j < cur_take; j++) exp[j] = model_q.pop_front();
    if (cur_sext && cur_take > 0 && exp[cur_take-1])
      for (int j = cur_take; j < DATA_W; j++) exp[j] = 1'b1;
    got = dout_data_o;
    check(req, 64'(got), 64'(exp));
    @(negedge clk_i);
    dout_ready_i = 1'b0;
  endtask

  task automatic drain();
    logic [DATA_W-1:0] got;
    while (model_q.size() > 0) begin
      set_oop(0, (model_q.size() > DATA_W) ? DATA_W : model_q.size(), 0);
      recv_word("R5 drain", got);
    end
    set_oop(0, 1, 0);
    #1;
    check("R5 empty after drain", 64'(dout_valid_o), 64'd0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 din_ready", 64'(din_ready_o), 64'd0);
    check("R1 dout_valid", 64'(dout_valid_o), 64'd0);
    check("R1 iop_ready", 64'(iop_ready_o), 64'd1);
    check("R1 oop_ready", 64'(oop_ready_o), 64'd1);
  endtask

  task automatic t_low_first();
    logic [DATA_W-1:0] got;
    set_iop(8, 1);
    send_word(37'h1A5);
    send_word(37'h3C);
    set_oop(0, 16, 0);
    recv_word("R3 R7 low first", got);
    check("R3 low first value", 64'(got), 64'h3CA5);
    drain();
  endtask

  task automatic t_high_first();
    logic [DATA_W-1:0] got;
    set_iop(4, 0);
    send_word(37'h1);
    send_word(37'h6);
    set_oop(0, 8, 0);
    recv_word("R3 high first", got);
    check("R3 high first value", 64'(got), 64'h68);
    drain();
  endtask

  task automatic t_drop_ext();
    logic [DATA_W-1:0] got;
    set_iop(12, 1);
    send_word(37'hF30);
    set_oop(4, 5, 1);
    recv_word("R6 R8 drop and sign extend", got);
    check("R8 sign extend value", 64'(got), 64'h1F_FFFF_FFF3);
    set_oop(0, 3, 0);
    recv_word("R8 zero extend", got);
    check("R8 zero extend value", 64'(got), 64'h7);
    send_word(37'hFFF);
    set_oop(2, 0, 1);
    recv_word("R8 take zero", got);
    check("R8 take zero value", 64'(got), 64'h0);
    drain();
  endtask

  task automatic t_pick();
    logic [DATA_W-1:0] got;
    set_iop(37, 1);
    send_word(37'd10000);
    send_word(37'd0);
    send_word(37'h1F_FFFF_FFFF);
    set_oop(37, 1, 1);
    recv_word("R11 pick first", got);
    check("R11 pick first value", 64'(got), 64'h0);
    recv_word("R9 R11 pick repeated", got);
    check("R11 pick second value", 64'(got), 64'h1F_FFFF_FFFF);
    drain();
  endtask

  task automatic t_full();
    logic [DATA_W-1:0] got;
    set_iop(37, 1);
    send_word(37'h12345);
    send_word(37'h0ABCDE);
    send_word(37'h1_0000_0001);
    @(negedge clk_i);
    din_valid_i = 1'b1; din_data_i = 37'h55;
    #1;
    check("R4 full blocks word", 64'(din_ready_o), 64'd0);
    @(negedge clk_i); #1;
    check("R4 still blocked", 64'(din_ready_o), 64'd0);
    din_valid_i = 1'b0;
    set_oop(0, 20, 0);
    recv_word("R4 read frees room", got);
    #1;
    check("R4 room after read", 64'(din_ready_o), 64'd1);
    send_word(37'h55);
    drain();
  endtask

  task automatic t_stall();
    logic [DATA_W-1:0] got, held;
    set_iop(8, 1);
    send_word(37'hC3);
    set_oop(0, 10, 0);
    #1;
    check("R5 too few bits", 64'(dout_valid_o), 64'd0);
    @(negedge clk_i); #1;
    check("R5 still too few", 64'(dout_valid_o), 64'd0);
    send_word(37'h81);
    #1;
    check("R5 enough bits", 64'(dout_valid_o), 64'd1);
    held = dout_data_o;
    @(negedge clk_i); #1;
    check("R12 valid held", 64'(dout_valid_o), 64'd1);
    check("R12 data held", 64'(dout_data_o), 64'(held));
    recv_word("R5 stalled word", got);
    drain();
  endtask

  task automatic t_swap();
    logic [DATA_W-1:0] got;
    set_iop(4, 1);
    @(negedge clk_i);
    iop_valid_i = 1'b1; iop_take_i = 6'd8; iop_lsb_first_i = 1'b1;
    din_valid_i = 1'b1; din_data_i = 37'hFF;
    @(negedge clk_i);
    iop_valid_i = 1'b0; din_valid_i = 1'b0;
    model_push(37'hFF, 4, 1);
    cur_in_take = 8;
    send_word(37'h00);
    set_oop(0, 12, 0);
    recv_word("R10 old op for same cycle word", got);
    check("R10 swap value", 64'(got), 64'hF);
    drain();
  endtask

  task automatic t_clamp();
    logic [DATA_W-1:0] got;
    set_iop(50, 1);
    send_word(37'h1F_FFFF_FFFF);
    set_oop(0, 37, 0);
    recv_word("R2 clamped take", got);
    check("R2 clamped value", 64'(got), 64'h1F_FFFF_FFFF);
    drain();
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=progress");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_low_first();
    t_high_first();
    t_drop_ext();
    t_pick();
    t_full();
    t_stall();
    t_swap();
    t_clamp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule